// File: doc/BRIEF.md
# Framed Serial Voice-Sample Port

This block sits between a parallel voice codec core and two bit-serial links. One link carries PCM samples and the other carries ADPCM codes. Each link has its own bit clock, and the two links share a transmit frame strobe and a receive frame strobe that recur once per 8 kHz frame. On transmit, the port takes a parallel PCM word and a parallel 4-bit ADPCM code when a frame starts, then shifts both out MSB first, one bit per rising edge of the matching bit clock. On receive, it samples serial PCM and ADPCM on falling bit-clock edges, MSB first. When the last bit of a word arrives, it shows the word in parallel together with a one-cycle valid pulse.

The PCM word length can change between frames. A format input selects either an 8-bit companded code or a 14-bit two's-complement linear code. In the linear code, 01111111111111 is positive full scale, 00000000000000 is zero and 10000000000000 is negative full scale. The ADPCM line is open drain: the port can only pull it low, and it releases the line whenever the active-low power-down input is asserted. The bit clocks, strobes and serial inputs are not related to the system clock. Each of them passes through a two-stage synchronizer before the port detects edges on it.

Top module: `voice_serial_port`

## Requirements
- R1: While reset is asserted, and after it, `pcm_sdo` is 0, `adp_pull_low` is 0 (line released), and both valid outputs are 0 until a frame is received.
- R2: The first bit-clock rising edge that finds the transmit strobe newly high loads the parallel word and launches its MSB. Each following rising edge launches the next lower bit.
- R3: With `linear_mode` = 0 the PCM word is 8 bits, taken from `tx_pcm_word[7:0]`. With `linear_mode` = 1 it is 14 bits, taken from `tx_pcm_word[13:0]`. The ADPCM word is always 4 bits.
- R4: After the LSB of a word, `pcm_sdo` stays 0 and the ADPCM line stays released until the next frame. Serial input bits that arrive after the LSB have no effect on the received word.
- R5: Serial input is sampled on the falling bit-clock edge, MSB first. After the LSB is sampled, the word appears on the parallel output with a valid pulse lasting one system clock. The word is held until the next word completes.
- R6: In 8-bit mode the received PCM word sits in bits [7:0] and bits [13:8] are 0.
- R7: A strobe that stays high for more than one bit-clock period starts only one frame. Its later high samples do not restart the word.
- R8: A new frame strobe that arrives before a word is complete restarts that lane at the MSB. The partial receive word is dropped and no valid pulse is given for it.
- R9: While a transmitted ADPCM bit is 0, `adp_pull_low` is 1. While the bit is 1, the line is released (`adp_pull_low` = 0).
- R10: While `pd_n` is 0, `adp_pull_low` is 0 for the whole frame. The PCM lanes and the ADPCM receive lane keep working.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pd_n | input | 1 | Active-low power-down; releases the ADPCM output |
| linear_mode | input | 1 | PCM format: 0 = 8-bit companded, 1 = 14-bit linear |
| pcm_bclk | input | 1 | PCM bit clock |
| adp_bclk | input | 1 | ADPCM bit clock |
| tx_sync | input | 1 | Transmit frame strobe (marks MSB) |
| rx_sync | input | 1 | Receive frame strobe (marks MSB) |
| tx_pcm_word | input | 14 | Parallel PCM word to send |
| tx_adp_code | input | 4 | Parallel ADPCM code to send |
| pcm_sdi | input | 1 | Serial PCM input |
| adp_sdi | input | 1 | Serial ADPCM input |
| pcm_sdo | output | 1 | Serial PCM output, 0 when idle |
| adp_pull_low | output | 1 | Open-drain ADPCM output: 1 pulls the line low, 0 releases it |
| rx_pcm_word | output | 14 | Received PCM word, right-justified |
| rx_pcm_valid | output | 1 | One-cycle strobe for a new received PCM word |
| rx_adp_code | output | 4 | Received ADPCM code |
| rx_adp_valid | output | 1 | One-cycle strobe for a new received ADPCM code |

## Verification
Directed frames carry the linear full-scale and zero codes and the all-ones and all-zeros companded bytes. These show whether the MSB-first order and the chosen word length are right at the extremes. Random words, with the format and power-down picked at random each frame, mix both word lengths and both line states, so a wrong bit index or a missing power-down release shows up. Random junk driven after each LSB shows whether the port stops sampling at the end of the word. A shortened frame, in which the next strobe cuts off a linear word, tells a correct restart apart from a spurious valid pulse. The strobe is held high for two PCM bit periods every frame, which catches a lane that restarts while the strobe stays high.

// File: rtl/vsp_pkg.sv
// Shared types and helpers for the framed serial voice-sample port.
package vsp_pkg;
    // PCM sample format chosen by the mode input
    typedef enum logic {
        FMT_COMPANDED = 1'b0,
        FMT_LINEAR    = 1'b1
    } pcm_fmt_e;

    // Number of PCM bits per frame for a given format
    function automatic int unsigned pcm_bits(pcm_fmt_e f, int unsigned lin_w, int unsigned cmp_w);
        return (f == FMT_LINEAR) ? lin_w : cmp_w;
    endfunction
endpackage

// File: rtl/vsp_sync.sv
// Multi-bit level synchronizer.
// Assumes each bit is an independent slow level; no bus coherency implied.
module vsp_sync #(
    parameter int N      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] d,
    output logic [N-1:0] q
);
    logic [N-1:0] st [STAGES];

    // first stage captures the asynchronous inputs
    always_ff @(posedge clk) begin
        if (!rst_n) st[0] <= '0;
        else        st[0] <= d;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        // later stages settle metastability
        always_ff @(posedge clk) begin
            if (!rst_n) st[s] <= '0;
            else        st[s] <= st[s-1];
        end
    end

    assign q = st[STAGES-1];
endmodule

// File: rtl/vsp_edge.sv
// Rise/fall detector for synchronized clock levels.
// Assumes inputs come from vsp_sync; outputs are one-cycle pulses.
module vsp_edge #(
    parameter int N = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl,
    output logic [N-1:0] rise,
    output logic [N-1:0] fall
);
    logic [N-1:0] prev;

    // remember last level for edge comparison
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= '0;
        else        prev <= lvl;
    end

    assign rise = lvl & ~prev;
    assign fall = ~lvl & prev;
endmodule

// File: rtl/vsp_tx_lane.sv
// Transmit shifter for one serial lane.
// Loads the word on the first bit-clock rise that sees the strobe newly high,
// then launches one bit per rise, MSB first; drives 0 and clears active when done.
// Assumes len is in 1..MAXW and MAXW >= 2.
module vsp_tx_lane #(
    parameter int MAXW = 14,
    parameter int LW   = $clog2(MAXW + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bclk_rise,
    input  logic            sync_lvl,
    input  logic [LW-1:0]   len,
    input  logic [MAXW-1:0] word,
    output logic            dout,
    output logic            active
);
    localparam int IW = $clog2(MAXW);

    logic            sync_q;
    logic            start;
    logic [MAXW-1:0] word_q;
    logic [LW-1:0]   cnt;
    logic            msb_in;
    logic            next_bit;

    assign start    = bclk_rise && sync_lvl && !sync_q;
    assign msb_in   = word[IW'(len - 1'b1)];
    assign next_bit = word_q[IW'(cnt - 1'b1)];

    // frame detection and MSB-first shifting on bit-clock rises
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= 1'b0;
            word_q <= '0;
            cnt    <= '0;
            dout   <= 1'b0;
            active <= 1'b0;
        end else if (bclk_rise) begin
            sync_q <= sync_lvl;
            if (start) begin
                word_q <= word;
                dout   <= msb_in;
                cnt    <= len - 1'b1;
                active <= 1'b1;
            end else if (active) begin
                if (cnt != '0) begin
                    dout <= next_bit;
                    cnt  <= cnt - 1'b1;
                end else begin
                    dout   <= 1'b0;
                    active <= 1'b0;
                end
            end
        end
    end

    // R2: a frame start launches the loaded word's MSB next cycle
    a_r2_msb_launch: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (active && dout == $past(msb_in)));

    // R4: an idle lane never drives a one
    a_r4_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> (dout == 1'b0));
endmodule

// File: rtl/vsp_rx_lane.sv
// Receive shifter for one serial lane.
// Arms on the first bit-clock rise that sees the strobe newly high, samples on
// falls MSB first, and posts the word with a one-cycle valid after len bits.
// A fresh strobe mid-word restarts the lane and drops the partial word.
// Assumes len is in 1..MAXW and MAXW >= 2.
module vsp_rx_lane #(
    parameter int MAXW = 14,
    parameter int LW   = $clog2(MAXW + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bclk_rise,
    input  logic            bclk_fall,
    input  logic            sync_lvl,
    input  logic [LW-1:0]   len,
    input  logic            din,
    output logic [MAXW-1:0] word,
    output logic            valid
);
    logic            sync_q;
    logic            active;
    logic [LW-1:0]   cnt;
    logic [LW-1:0]   len_q;
    logic [MAXW-1:0] sh;

    // arm on strobe, shift on falls, publish completed words
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= 1'b0;
            active <= 1'b0;
            cnt    <= '0;
            len_q  <= '0;
            sh     <= '0;
            word   <= '0;
            valid  <= 1'b0;
        end else begin
            valid <= 1'b0;
            if (bclk_rise) begin
                sync_q <= sync_lvl;
                if (sync_lvl && !sync_q) begin
                    active <= 1'b1;
                    cnt    <= '0;
                    sh     <= '0;
                    len_q  <= len;
                end
            end
            if (bclk_fall && active) begin
                sh <= {sh[MAXW-2:0], din};
                if (cnt == len_q - 1'b1) begin
                    word   <= {sh[MAXW-2:0], din};
                    valid  <= 1'b1;
                    active <= 1'b0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    // R5: valid lasts exactly one system cycle
    a_r5_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> !valid);

    // R6: bits above the word length are zero when a word is posted
    a_r6_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> ((word >> len_q) == '0));

    // R8: a new strobe rearms the lane at the MSB position
    a_r8_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (bclk_rise && sync_lvl && !sync_q) |=> (active && cnt == '0));
endmodule

// File: rtl/voice_serial_port.sv
// Framed serial voice-sample port: PCM and ADPCM serial links with separate
// bit clocks, shared transmit and receive strobes, switchable 8/14-bit PCM
// and an open-drain ADPCM output released during power-down.
// Assumes bit clocks are much slower than clk (at least 4 clk per half period)
// and that linear_mode changes only between frames.
module voice_serial_port #(
    parameter int LIN_W       = 14,
    parameter int CMP_W       = 8,
    parameter int ADP_W       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pd_n,
    input  logic             linear_mode,
    input  logic             pcm_bclk,
    input  logic             adp_bclk,
    input  logic             tx_sync,
    input  logic             rx_sync,
    input  logic [LIN_W-1:0] tx_pcm_word,
    input  logic [ADP_W-1:0] tx_adp_code,
    input  logic             pcm_sdi,
    input  logic             adp_sdi,
    output logic             pcm_sdo,
    output logic             adp_pull_low,
    output logic [LIN_W-1:0] rx_pcm_word,
    output logic             rx_pcm_valid,
    output logic [ADP_W-1:0] rx_adp_code,
    output logic             rx_adp_valid
);
    import vsp_pkg::*;

    localparam int PLW = $clog2(LIN_W + 1);
    localparam int ALW = $clog2(ADP_W + 1);

    logic [5:0] raw_in;
    logic [5:0] syn;
    logic [1:0] ck_rise;
    logic [1:0] ck_fall;
    logic       adp_bit;
    logic       adp_act;
    logic       pcm_act;
    pcm_fmt_e   fmt;
    logic [PLW-1:0] pcm_len;
    logic [ALW-1:0] adp_len;

    assign raw_in  = {adp_sdi, pcm_sdi, rx_sync, tx_sync, adp_bclk, pcm_bclk};
    assign fmt     = pcm_fmt_e'(linear_mode);
    assign pcm_len = PLW'(pcm_bits(fmt, LIN_W, CMP_W));
    assign adp_len = ALW'(ADP_W);

    vsp_sync #(.N(6), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(raw_in), .q(syn)
    );

    vsp_edge #(.N(2)) u_edge (
        .clk(clk), .rst_n(rst_n), .lvl(syn[1:0]), .rise(ck_rise), .fall(ck_fall)
    );

    vsp_tx_lane #(.MAXW(LIN_W), .LW(PLW)) u_pcm_tx (
        .clk(clk), .rst_n(rst_n), .bclk_rise(ck_rise[0]), .sync_lvl(syn[2]),
        .len(pcm_len), .word(tx_pcm_word), .dout(pcm_sdo), .active(pcm_act)
    );

    vsp_tx_lane #(.MAXW(ADP_W), .LW(ALW)) u_adp_tx (
        .clk(clk), .rst_n(rst_n), .bclk_rise(ck_rise[1]), .sync_lvl(syn[2]),
        .len(adp_len), .word(tx_adp_code), .dout(adp_bit), .active(adp_act)
    );

    vsp_rx_lane #(.MAXW(LIN_W), .LW(PLW)) u_pcm_rx (
        .clk(clk), .rst_n(rst_n), .bclk_rise(ck_rise[0]), .bclk_fall(ck_fall[0]),
        .sync_lvl(syn[3]), .len(pcm_len), .din(syn[4]),
        .word(rx_pcm_word), .valid(rx_pcm_valid)
    );

    vsp_rx_lane #(.MAXW(ADP_W), .LW(ALW)) u_adp_rx (
        .clk(clk), .rst_n(rst_n), .bclk_rise(ck_rise[1]), .bclk_fall(ck_fall[1]),
        .sync_lvl(syn[3]), .len(adp_len), .din(syn[5]),
        .word(rx_adp_code), .valid(rx_adp_valid)
    );

    // open-drain: only zero bits of an active word pull low, never in power-down
    assign adp_pull_low = pd_n && adp_act && !adp_bit;

    // R4: the PCM lane outputs zero whenever it is between words
    a_r4_pcm_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !pcm_act |-> !pcm_sdo);
endmodule

// File: tb/voice_serial_port_test.sv
module voice_serial_port_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pd_n = 1'b1;
    logic        linear_mode = 1'b1;
    logic        pcm_bclk = 1'b0;
    logic        adp_bclk = 1'b0;
    logic        tx_sync = 1'b0;
    logic        rx_sync = 1'b0;
    logic [13:0] tx_pcm_word = '0;
    logic [3:0]  tx_adp_code = '0;
    logic        pcm_sdi = 1'b0;
    logic        adp_sdi = 1'b0;
    logic        pcm_sdo;
    logic        adp_pull_low;
    logic [13:0] rx_pcm_word;
    logic        rx_pcm_valid;
    logic [3:0]  rx_adp_code;
    logic        rx_adp_valid;

    int vectors = 0;
    int fails   = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    voice_serial_port uut (
        .clk(clk), .rst_n(rst_n), .pd_n(pd_n), .linear_mode(linear_mode),
        .pcm_bclk(pcm_bclk), .adp_bclk(adp_bclk), .tx_sync(tx_sync), .rx_sync(rx_sync),
        .tx_pcm_word(tx_pcm_word), .tx_adp_code(tx_adp_code),
        .pcm_sdi(pcm_sdi), .adp_sdi(adp_sdi), .pcm_sdo(pcm_sdo), .adp_pull_low(adp_pull_low),
        .rx_pcm_word(rx_pcm_word), .rx_pcm_valid(rx_pcm_valid),
        .rx_adp_code(rx_adp_code), .rx_adp_valid(rx_adp_valid)
    );

    task automatic check(string req, logic [31:0] got, logic [31:0] exp);
        vectors++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%0h exp=%0h", req, got, exp);
        end
    endtask

    // expected parallel PCM word after reception (R3, R6)
    function automatic logic [13:0] pcm_expect(bit lin, logic [13:0] w);
        return lin ? w : {6'b0, w[7:0]};
    endfunction

    // one frame; flen cycles (multiple of 32), strobes high for 32 cycles
    task automatic run_frame(int flen, bit lin, bit pdn, logic [13:0] txw, logic [3:0] txa,
                             logic [13:0] rxw, logic [3:0] rxa, int exp_pv, int exp_av);
        int plen = lin ? 14 : 8;
        int pv = 0;
        int av = 0;
        linear_mode = lin;
        pd_n        = pdn;
        tx_pcm_word = txw;
        tx_adp_code = txa;
        for (int p = 0; p < flen; p++) begin
            @(negedge clk);
            if (rx_pcm_valid) begin
                pv++;
                check("R5/R6 rx pcm word", 32'(rx_pcm_word), 32'(pcm_expect(lin, rxw)));
            end
            if (rx_adp_valid) begin
                av++;
                check("R5 rx adpcm code", 32'(rx_adp_code), 32'(rxa));
            end
            if (p >= 16 && (p % 16) == 0) begin
                int k = (p - 16) / 16;
                if (k < plen) check("R2/R3/R7 pcm tx bit", 32'(pcm_sdo), 32'(txw[plen-1-k]));
                else          check("R4 pcm idle", 32'(pcm_sdo), 32'd0);
            end
            if (p >= 24 && ((p - 24) % 32) == 0) begin
                int k = (p - 24) / 32;
                if (k < 4) check("R9/R10 adpcm pull", 32'(adp_pull_low), 32'(pdn && !txa[3-k]));
                else       check("R4 adpcm released", 32'(adp_pull_low), 32'd0);
            end
            pcm_bclk = ((p + 8) % 16) < 8;
            adp_bclk = ((p + 24) % 32) < 16;
            tx_sync  = (p < 32);
            rx_sync  = (p < 32);
            if (p >= 8 && ((p - 8) % 16) == 0) begin
                int k = (p - 8) / 16;
                pcm_sdi = (k < plen) ? rxw[plen-1-k] : 1'($urandom % 2);
            end
            if (p >= 8 && ((p - 8) % 32) == 0) begin
                int k = (p - 8) / 32;
                adp_sdi = (k < 4) ? rxa[3-k] : 1'($urandom % 2);
            end
        end
        check("R5/R8 pcm valid count", 32'(pv), 32'(exp_pv));
        check("R5 adpcm valid count", 32'(av), 32'(exp_av));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (5) @(negedge clk);
        // R1: reset state
        check("R1 pcm_sdo in reset", 32'(pcm_sdo), 32'd0);
        check("R1 adpcm released in reset", 32'(adp_pull_low), 32'd0);
        check("R1 no pcm valid", 32'(rx_pcm_valid), 32'd0);
        check("R1 no adpcm valid", 32'(rx_adp_valid), 32'd0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check("R1 pcm_sdo after reset", 32'(pcm_sdo), 32'd0);

        // directed: linear extremes, companded extremes
        run_frame(320, 1'b1, 1'b1, 14'h1FFF, 4'h0, 14'h2000, 4'hF, 1, 1);
        run_frame(320, 1'b1, 1'b1, 14'h2000, 4'hF, 14'h1FFF, 4'h0, 1, 1);
        run_frame(320, 1'b1, 1'b1, 14'h0000, 4'hA, 14'h0000, 4'h5, 1, 1);
        run_frame(320, 1'b0, 1'b1, 14'h3FFF, 4'h5, 14'h3FFF, 4'hA, 1, 1);
        run_frame(320, 1'b0, 1'b1, 14'h3F00, 4'h3, 14'h3F00, 4'hC, 1, 1);
        // R10: power-down releases the ADPCM line
        run_frame(320, 1'b1, 1'b0, 14'h1555, 4'h0, 14'h0AAA, 4'h6, 1, 1);
        // R8: short frame cuts the linear word; next frame restarts cleanly
        run_frame(128, 1'b1, 1'b1, 14'h2AAA, 4'h9, 14'h1234, 4'h7, 0, 1);
        run_frame(320, 1'b1, 1'b1, 14'h0F0F, 4'h2, 14'h3C3C, 4'hB, 1, 1);
        // random frames
        for (int i = 0; i < 16; i++) begin
            run_frame(320, 1'($urandom % 2), 1'($urandom % 4 != 0),
                      14'($urandom), 4'($urandom), 14'($urandom), 4'($urandom), 1, 1);
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule